// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style UART reports to its host. The receiver, the transmitter and the modem-status logic each send event pulses, and the host register decoder sends one-cycle access strobes. For each of five sources the block holds a latched pending bit, and each bit is cleared only by the register access that belongs to that source. Every pending bit is gated by its bit in the interrupt enable register. The enabled source with the highest priority is reported as an encoded identification byte, and a single interrupt request line goes with it.

The block also contains the receive character-timeout counter. The clocks-per-character value comes from the baud logic, and the receive FIFO fill level comes from the FIFO. The block itself has no shifting, no baud generation and no FIFO storage. It keeps sticky copies of the four line-error flags and the four modem-status change flags so that they can be merged into the LSR and MSR read data.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_o` is 0xC1 and `irq_o`, `lsr_err_o` and `msr_delta_o` are all zero.
- R2: The identification byte is `{2'b11, 2'b00, code}`. Code 0x1 means nothing is pending. The source codes are line status 0x6, received data 0x4, character timeout 0xC, transmit empty 0x2 and modem status 0x0. When several enabled sources are pending, the reported one is taken in this order: line status, received data, timeout, transmit empty, modem status.
- R3: A pulse on any `err_set` bit sets that bit of `lsr_err_o` and makes line status pending. An `lsr_rd` strobe clears all four error bits and the line-status pending bit.
- R4: Received data is pending while `rx_count` is at or above the trigger level. In FIFO mode (the last FCR write had bit 0 set), FCR bits 7:6 select a level of 1, DEPTH/4, DEPTH/2 or DEPTH-2; for DEPTH 16 these are 1, 4, 8 and 14. Outside FIFO mode the level is 1.
- R5: IER bit 0 enables both received data and timeout. IER bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R6: Timeout becomes pending after TO_CHARS×`char_time` consecutive cycles in which `rx_count` is nonzero and neither `rx_push` nor `rbr_rd` occurs. Either strobe restarts the count, and `rx_push` also clears a pending timeout. `char_time` must be at least 1.
- R7: `rbr_rd` clears the received-data and timeout pending bits. The data condition is checked again on the next cycle against the new `rx_count`.
- R8: A `tx_empty` pulse makes transmit empty pending. `thr_wr` always clears it. `iir_rd` clears it only while code 0x2 is the one being reported.
- R9: A pulse on any `msr_delta_set` bit sets that bit of `msr_delta_o` and makes modem status pending. `msr_rd` clears the change bits and the pending bit.
- R10: `irq_o` is high exactly when an enabled source is pending. An `ier_wr` changes the identification in the cycle after the write. A source that is pending but disabled stays latched and is reported once it is enabled.
- R11: An FCR write with bit 0 and bit 2 set makes transmit empty pending. An FCR write with bit 1 set clears the received-data and timeout pending bits.
- R12: When a clearing access and a setting event reach the same source in the same cycle, the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 8 | Host write data for IER and FCR writes |
| thr_wr | input | 1 | Write strobe, transmit holding register |
| ier_wr | input | 1 | Write strobe, interrupt enable register |
| fcr_wr | input | 1 | Write strobe, FIFO control register |
| rbr_rd | input | 1 | Read strobe, receive buffer |
| iir_rd | input | 1 | Read strobe, identification register |
| lsr_rd | input | 1 | Read strobe, line status register |
| msr_rd | input | 1 | Read strobe, modem status register |
| err_set | input | 4 | Error pulses: overrun, parity, framing, break |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_count | input | CNT_W | Receive FIFO fill level |
| char_time | input | CHAR_W | Clock cycles per character |
| tx_empty | input | 1 | Transmit holding register drained |
| msr_delta_set | input | 4 | Modem line change pulses |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |
| lsr_err_o | output | 4 | Sticky line error bits |
| msr_delta_o | output | 4 | Sticky modem change bits |

## Verification
The hardest state to reach from the ports is a character timeout, because it needs an uninterrupted idle stretch of exact length while the FIFO holds data and the received-data trigger is not met. The stimulus first selects a FIFO trigger of 4 and holds the fill level below it. It then checks the code in the cycle just before the timeout matures and in the cycle it matures. Next it restarts the window partway through with a second push and checks that maturity moves later. A second hard case is a transmit-empty source hidden under a line error: the test reads the identification byte while the line error is being reported, then proves that the transmit-empty bit survived that read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC = 5;

   typedef enum logic [2:0] {
      SRC_LINE    = 3'd0,
      SRC_RXDATA  = 3'd1,
      SRC_RXTMO   = 3'd2,
      SRC_TXEMPTY = 3'd3,
      SRC_MODEM   = 3'd4
   } src_e;

   localparam logic [3:0] CODE_NONE = 4'h1;

   function automatic logic [3:0] src_code(input logic [2:0] idx);
      case (idx)
         SRC_LINE:    return 4'h6;
         SRC_RXDATA:  return 4'h4;
         SRC_RXTMO:   return 4'hC;
         SRC_TXEMPTY: return 4'h2;
         default:     return 4'h0;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter int N  = 5,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            hit_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
   parameter int CHAR_W   = 12,
   parameter int TO_CHARS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              has_data_i,
   input  logic [CHAR_W-1:0] char_time_i,
   output logic              fire_o
);
   localparam int LIM_W = CHAR_W + $clog2(TO_CHARS) + 1;

   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt_q;
   logic             idle;

   generate
      if ((TO_CHARS & (TO_CHARS - 1)) == 0) begin : g_shift
         assign limit = LIM_W'(char_time_i) << $clog2(TO_CHARS);
      end else begin : g_mult
         assign limit = LIM_W'(char_time_i) * LIM_W'(TO_CHARS);
      end
   endgenerate

   assign idle = has_data_i & ~restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!idle)           cnt_q <= '0;
      else if (cnt_q != limit)  cnt_q <= cnt_q + LIM_W'(1);
   end

   assign fire_o = idle && ((cnt_q + LIM_W'(1)) == limit);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int CHAR_W     = 12,
   parameter int TO_CHARS   = 4,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       wdata,
   input  logic             thr_wr,
   input  logic             ier_wr,
   input  logic             fcr_wr,
   input  logic             rbr_rd,
   input  logic             iir_rd,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   input  logic [3:0]       err_set,
   input  logic             rx_push,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CHAR_W-1:0] char_time,
   input  logic             tx_empty,
   input  logic [3:0]       msr_delta_set,
   output logic [7:0]       iir_o,
   output logic             irq_o,
   output logic [3:0]       lsr_err_o,
   output logic [3:0]       msr_delta_o
);
   localparam int IW = $clog2(NSRC);

   generate
      if (FIFO_DEPTH < 4 || FIFO_DEPTH > 256) begin : g_bad_depth
         $error("uart_irq_ident: FIFO_DEPTH out of range");
      end
      if (TO_CHARS < 1 || TO_CHARS > 16) begin : g_bad_tmo
         $error("uart_irq_ident: TO_CHARS out of range");
      end
      if (CHAR_W < 2) begin : g_bad_char
         $error("uart_irq_ident: CHAR_W too small");
      end
   endgenerate

   logic [3:0]       ier_q;
   logic             fifo_en_q;
   logic [1:0]       trig_sel_q;
   logic [CNT_W-1:0] trig_lvl;
   logic             rx_flush, tx_rst_thre, tmo_fire, data_hit;
   logic [NSRC-1:0]  pend_set, pend_clr, pend_q, src_en, req;
   logic             hit;
   logic [IW-1:0]    idx;
   logic [3:0]       code;
   logic             unused_wbits;

   assign unused_wbits = ^wdata[5:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q      <= '0;
         fifo_en_q  <= 1'b0;
         trig_sel_q <= '0;
         lsr_err_o  <= '0;
         msr_delta_o <= '0;
      end else begin
         if (ier_wr) ier_q <= wdata[3:0];
         if (fcr_wr) begin
            fifo_en_q  <= wdata[0];
            trig_sel_q <= wdata[7:6];
         end
         lsr_err_o   <= lsr_rd ? 4'h0 : (lsr_err_o | err_set);
         msr_delta_o <= msr_rd ? 4'h0 : (msr_delta_o | msr_delta_set);
      end
   end

   always_comb begin
      if (!fifo_en_q) trig_lvl = CNT_W'(1);
      else begin
         case (trig_sel_q)
            2'd0:    trig_lvl = CNT_W'(1);
            2'd1:    trig_lvl = CNT_W'(FIFO_DEPTH / 4);
            2'd2:    trig_lvl = CNT_W'(FIFO_DEPTH / 2);
            default: trig_lvl = CNT_W'(FIFO_DEPTH - 2);
         endcase
      end
   end

   assign rx_flush    = fcr_wr & wdata[1];
   assign tx_rst_thre = fcr_wr & wdata[0] & wdata[2];
   assign data_hit    = (rx_count >= trig_lvl);

   uart_irq_tmo #(.CHAR_W(CHAR_W), .TO_CHARS(TO_CHARS)) tmo_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (rx_push | rbr_rd | rx_flush),
      .has_data_i (rx_count != '0),
      .char_time_i(char_time),
      .fire_o     (tmo_fire)
   );

   always_comb begin
      pend_set = '0;
      pend_clr = '0;
      pend_set[SRC_LINE]    = |err_set;
      pend_clr[SRC_LINE]    = lsr_rd;
      pend_set[SRC_RXDATA]  = data_hit;
      pend_clr[SRC_RXDATA]  = rbr_rd | rx_flush;
      pend_set[SRC_RXTMO]   = tmo_fire;
      pend_clr[SRC_RXTMO]   = rbr_rd | rx_push | rx_flush;
      pend_set[SRC_TXEMPTY] = tx_empty | tx_rst_thre;
      pend_clr[SRC_TXEMPTY] = thr_wr | (iir_rd & hit & (idx == IW'(SRC_TXEMPTY)));
      pend_set[SRC_MODEM]   = |msr_delta_set;
      pend_clr[SRC_MODEM]   = msr_rd;
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         uart_irq_flag flag_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(pend_set[s]),
            .clr_i(pend_clr[s]),
            .q_o  (pend_q[s])
         );
      end
   endgenerate

   assign src_en[SRC_LINE]    = ier_q[2];
   assign src_en[SRC_RXDATA]  = ier_q[0];
   assign src_en[SRC_RXTMO]   = ier_q[0];
   assign src_en[SRC_TXEMPTY] = ier_q[1];
   assign src_en[SRC_MODEM]   = ier_q[3];
   assign req = pend_q & src_en;

   uart_irq_prio #(.N(NSRC), .IW(IW)) prio_i (
      .req_i(req),
      .hit_o(hit),
      .idx_o(idx)
   );

   assign code  = hit ? src_code(3'(idx)) : CODE_NONE;
   assign iir_o = {4'b1100, code};
   assign irq_o = hit;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lsr_rd,
   input logic             msr_rd,
   input logic             thr_wr,
   input logic             rbr_rd,
   input logic [CNT_W-1:0] rx_count,
   input logic [7:0]       iir_o,
   input logic             irq_o,
   input logic [3:0]       lsr_err_o,
   input logic [3:0]       msr_delta_o,
   input logic [4:0]       pend,
   input logic [3:0]       ier
);
   // R2: an enabled line error always wins
   assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && ier[2]) |-> (iir_o[3:0] == 4'h6));

   assert_lsr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd |=> (lsr_err_o == 4'h0 && iir_o[3:0] != 4'h6));

   assert_tmo_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[2]) |-> ($past(rx_count) != '0));

   assert_rbr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rbr_rd |=> (pend[2] == 1'b0 && pend[1] == 1'b0));

   assert_thr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> (iir_o[3:0] != 4'h2));

   assert_msr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      msr_rd |=> (msr_delta_o == 4'h0 && iir_o[3:0] != 4'h0));

   assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ier != 4'h0));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .lsr_rd     (lsr_rd),
   .msr_rd     (msr_rd),
   .thr_wr     (thr_wr),
   .rbr_rd     (rbr_rd),
   .rx_count   (rx_count),
   .iir_o      (iir_o),
   .irq_o      (irq_o),
   .lsr_err_o  (lsr_err_o),
   .msr_delta_o(msr_delta_o),
   .pend       (pend_q),
   .ier        (ier_q)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wdata = '0;
   logic thr_wr = 0, ier_wr = 0, fcr_wr = 0, rbr_rd = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0;
   logic [3:0] err_set = '0, msr_delta_set = '0;
   logic       rx_push = 0, tx_empty = 0;
   logic [4:0] rx_count = '0;
   logic [11:0] char_time = 12'd3;
   logic [7:0] iir_o;
   logic       irq_o;
   logic [3:0] lsr_err_o, msr_delta_o;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_irq_ident dut_i (
      .clk(clk), .rst_n(rst_n), .wdata(wdata), .thr_wr(thr_wr), .ier_wr(ier_wr),
      .fcr_wr(fcr_wr), .rbr_rd(rbr_rd), .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
      .err_set(err_set), .rx_push(rx_push), .rx_count(rx_count), .char_time(char_time),
      .tx_empty(tx_empty), .msr_delta_set(msr_delta_set), .iir_o(iir_o), .irq_o(irq_o),
      .lsr_err_o(lsr_err_o), .msr_delta_o(msr_delta_o)
   );

   localparam logic [3:0] OP_IER = 0, OP_ERR = 1, OP_LSR = 2, OP_TXE = 3, OP_THR = 4,
                          OP_IIR = 5, OP_MSD = 6, OP_MSR = 7, OP_FCR = 8;
   localparam int NVEC = 21;
   // {op, data, expected iir}
   localparam logic [19:0] VEC [0:NVEC-1] = '{
      {OP_IER, 8'h0F, 8'hC1}, {OP_MSD, 8'h01, 8'hC0}, {OP_TXE, 8'h00, 8'hC2},
      {OP_ERR, 8'h01, 8'hC6}, {OP_LSR, 8'h00, 8'hC2}, {OP_IIR, 8'h00, 8'hC0},
      {OP_TXE, 8'h00, 8'hC2}, {OP_ERR, 8'h04, 8'hC6}, {OP_IIR, 8'h00, 8'hC6},
      {OP_LSR, 8'h00, 8'hC2}, {OP_THR, 8'h00, 8'hC0}, {OP_IER, 8'h00, 8'hC1},
      {OP_TXE, 8'h00, 8'hC1}, {OP_IER, 8'h02, 8'hC2}, {OP_IER, 8'h08, 8'hC0},
      {OP_MSR, 8'h00, 8'hC1}, {OP_IER, 8'h0A, 8'hC2}, {OP_THR, 8'h00, 8'hC1},
      {OP_FCR, 8'h05, 8'hC2}, {OP_THR, 8'h00, 8'hC1}, {OP_FCR, 8'h04, 8'hC1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      thr_wr = 0; ier_wr = 0; fcr_wr = 0; rbr_rd = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
      err_set = '0; msr_delta_set = '0; rx_push = 0; tx_empty = 0;
   endtask

   task automatic do_op(input logic [3:0] op, input logic [7:0] d);
      wdata = d;
      case (op)
         OP_IER: ier_wr = 1;
         OP_ERR: err_set = d[3:0];
         OP_LSR: lsr_rd = 1;
         OP_TXE: tx_empty = 1;
         OP_THR: thr_wr = 1;
         OP_IIR: iir_rd = 1;
         OP_MSD: msr_delta_set = d[3:0];
         OP_MSR: msr_rd = 1;
         OP_FCR: fcr_wr = 1;
         default: ;
      endcase
      step();
      clear_strobes();
   endtask

   task automatic push(input logic [4:0] n);
      rx_count = n; rx_push = 1;
      step();
      clear_strobes();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk("R1 iir", iir_o, 8'hC1);
      chk("R1 irq", {7'd0, irq_o}, 8'h00);
      chk("R1 lsr", {4'd0, lsr_err_o}, 8'h00);
      chk("R1 msr", {4'd0, msr_delta_o}, 8'h00);
      rst_n = 1;
      step();

      // R2 R8 R10 R11 priority and clearing table
      for (int v = 0; v < NVEC; v++) begin
         do_op(VEC[v][19:16], VEC[v][15:8]);
         chk($sformatf("R2/R8/R10/R11 vec%0d iir", v), iir_o, VEC[v][7:0]);
         chk($sformatf("R10 vec%0d irq", v), {7'd0, irq_o}, {7'd0, ~VEC[v][0]});
      end

      do_op(OP_IER, 8'h0F);
      // R4 non-FIFO trigger of 1
      push(5'd1);
      chk("R4 nonfifo trig", iir_o, 8'hC4);
      rbr_rd = 1; step(); clear_strobes();
      chk("R7 read clears", iir_o, 8'hC1);
      rx_count = 0; step();
      chk("R7 empty stays clear", iir_o, 8'hC1);

      // R4 FIFO trigger 4
      do_op(OP_FCR, 8'h41);
      push(5'd3);
      chk("R4 below trig", iir_o, 8'hC1);
      push(5'd4);
      chk("R4 at trig", iir_o, 8'hC4);
      push(5'd5);
      rbr_rd = 1; step(); clear_strobes();
      chk("R7 read clears fifo", iir_o, 8'hC1);
      rx_count = 5'd4; step();
      chk("R7 re-evaluate", iir_o, 8'hC4);
      rx_count = 0; do_op(OP_FCR, 8'h43);
      chk("R11 rx flush", iir_o, 8'hC1);

      // R6 timeout after 4*3 idle cycles
      push(5'd1);
      idle(11);
      chk("R6 before timeout", iir_o, 8'hC1);
      idle(1);
      chk("R6 timeout", iir_o, 8'hCC);
      do_op(OP_IER, 8'h0E);
      chk("R5 disabled timeout", iir_o, 8'hC1);
      do_op(OP_IER, 8'h0F);
      chk("R5 reenabled timeout", iir_o, 8'hCC);
      push(5'd2);
      chk("R6 push clears", iir_o, 8'hC1);
      idle(6);
      push(5'd3);
      idle(11);
      chk("R6 restart window", iir_o, 8'hC1);
      idle(1);
      chk("R6 restarted timeout", iir_o, 8'hCC);
      rbr_rd = 1; step(); clear_strobes();
      chk("R7 read clears timeout", iir_o, 8'hC1);
      rx_count = 5'd2; step();

      // R12 clear wins over same-cycle set
      err_set = 4'h2; lsr_rd = 1; step(); clear_strobes();
      chk("R12 lsr bits", {4'd0, lsr_err_o}, 8'h00);
      chk("R12 iir", iir_o, 8'hC1);

      // R3 sticky line errors
      do_op(OP_ERR, 8'h03);
      chk("R3 lsr bits", {4'd0, lsr_err_o}, 8'h03);
      chk("R3 iir", iir_o, 8'hC6);
      do_op(OP_LSR, 8'h00);
      chk("R3 lsr cleared", {4'd0, lsr_err_o}, 8'h00);
      // R9 modem changes
      do_op(OP_MSD, 8'h05);
      chk("R9 msr bits", {4'd0, msr_delta_o}, 8'h05);
      chk("R9 iir", iir_o, 8'hC0);
      do_op(OP_MSR, 8'h00);
      chk("R9 msr cleared", {4'd0, msr_delta_o}, 8'h00);
      chk("R9 iir cleared", iir_o, 8'hC1);
      rx_count = 0;
      step();

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule